// File: doc/BRIEF.md
# Command packet channel controller

This block runs one command packet on one channel. Software sets a packet pointer, a packet count, two FIFO thresholds and a control word through a small register file, then writes the control word with the go bit set. The engine reads the packet header through a word-addressed memory port and checks the valid flag. It then hands the register-pair section, the pair count, the descriptor-chain pointer and the data-phase flag to the downstream sequencers with a one-cycle start pulse.

When the sequencers report completion, the engine writes a response byte into byte 0 of the packet in memory. It records the outcome in a sticky status byte. The interrupt line is high while that byte is nonzero and the mask bit is clear. Faults also go to the status byte: a misaligned pointer, a packet without its valid flag, or a completion report that nobody asked for.

Top module: `pktchan_ctrl`

## Requirements
- R1: After reset the control word and the status byte both read 0, `irq` is 0 and `mem_req` is 0.
- R2: Register offsets are byte offsets on `reg_addr`: control 0x00, status 0x02, packet count 0x04 (16 bits), packet pointer 0x0C (32 bits), input threshold 0x14 (16 bits), output threshold 0x16 (16 bits). Control bit 8 is the interrupt mask, bit 5 is the engine reset and bits 1:0 are the PIO mode. These bits read back as written and drive `pio_mode`. Control bit 7 (go) always reads 0.
- R3: A go write with an 8-byte-aligned pointer P reads memory word P/4 first, then word P/4+2. If the valid flag is set, one `seq_start` pulse follows. Header word 0 holds the response in bits 7:0, the control byte in bits 23:16 (bit 16 valid, bit 18 data phase, bit 19 interrupt enable) and the length in bits 31:24. With that pulse, `seq_regs_ptr` is P+16, `seq_pair_cnt` is 4 times the length, `seq_prd_ptr` is word P/4+2, and `seq_has_data` is header bit 18.
- R4: After `seq_done`, the engine writes word P/4 with `mem_be`=0001. The data is 0x01, or 0x09 if `seq_dev_err` was high together with `seq_done`.
- R5: Once that write is acknowledged, status bit 2 is set if the header's interrupt-enable flag was set. Otherwise the status byte is left unchanged.
- R6: If the valid flag (header bit 16) is clear, status bit 6 is set. The engine returns to idle with no `seq_start` and no write.
- R7: If the pointer's bits 2:0 are nonzero at go, status bit 0 is set and no memory request is made.
- R8: A `seq_done` while the engine is not waiting for one sets status bit 4.
- R9: A read of the status byte returns it and clears it. `irq` is high exactly while the status byte is nonzero and control bit 8 is 0.
- R10: A go write while the engine is busy is ignored: no extra fetch, launch or write.
- R11: While control bit 5 is set, the engine is held idle, `mem_req` drops and the status byte stays clear. After the bit is cleared, the aborted packet gets no response write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status at 0x02) |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write when high |
| mem_addr | output | 30 | Memory word address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, read data valid with it |
| mem_rdata | input | 32 | Memory read data |
| seq_start | output | 1 | One-cycle launch pulse to the sequencers |
| seq_regs_ptr | output | 32 | Byte address of the register-pair section |
| seq_pair_cnt | output | 10 | Number of register pairs |
| seq_prd_ptr | output | 32 | Descriptor-chain pointer |
| seq_has_data | output | 1 | Packet carries a data phase |
| seq_done | input | 1 | Sequencers finished |
| seq_dev_err | input | 1 | Device reported an error, valid with seq_done |
| pio_mode | output | 2 | PIO mode field of the control word |
| irq | output | 1 | Interrupt request |

## Verification
The bench tries a go write while the engine waits on the sequencers. A design that accepts it would fetch the header again, and the memory scoreboard would see reads it did not expect. It sends an invalid header and a misaligned pointer; a design that launched anyway would make a start pulse or a memory request with nothing queued to match it. It raises the engine reset in the middle of a packet and then reports completion. This exposes a design that still writes the response byte, or that does not flag the late done as unexpected. It also compares the status byte against `irq` with the mask set, which catches a design that lets masking clear the status or lets the mask leak into it.

// File: rtl/pktchan_pkg.sv
`timescale 1ns/1ps
package pktchan_pkg;
  localparam int PTR_W = 32;
  localparam int WA_W  = PTR_W - 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR0, ST_HDR2, ST_LAUNCH, ST_WAIT, ST_RESP
  } eng_state_t;

  localparam logic [4:0] OFS_CTRL = 5'h00;
  localparam logic [4:0] OFS_STAT = 5'h02;
  localparam logic [4:0] OFS_CNT  = 5'h04;
  localparam logic [4:0] OFS_PTR  = 5'h0C;
  localparam logic [4:0] OFS_TIN  = 5'h14;
  localparam logic [4:0] OFS_TOUT = 5'h16;

  localparam int CB_MASK = 8;
  localparam int CB_GO   = 7;
  localparam int CB_RST  = 5;

  localparam int SB_BUSERR = 0;
  localparam int SB_DONE   = 2;
  localparam int SB_UNEXP  = 4;
  localparam int SB_PROTO  = 6;

  localparam int HB_VALID = 0;
  localparam int HB_DATA  = 2;
  localparam int HB_IEN   = 3;

  function automatic logic [9:0] pair_count(input logic [7:0] len);
    return {len, 2'b00};
  endfunction

  function automatic logic [PTR_W-1:0] pairs_base(input logic [PTR_W-1:0] p);
    return p + PTR_W'(16);
  endfunction

  function automatic logic misaligned(input logic [PTR_W-1:0] p);
    return |p[2:0];
  endfunction

  function automatic logic [7:0] resp_byte(input logic dev_err);
    return {4'b0000, dev_err, 3'b001};
  endfunction
endpackage

// File: rtl/pktchan_regs.sv
`timescale 1ns/1ps
module pktchan_regs
  import pktchan_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int THR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [4:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             ev_buserr,
  input  logic             ev_done,
  input  logic             ev_unexp,
  input  logic             ev_proto,
  output logic             go_pulse,
  output logic             soft_rst,
  output logic [PTR_W-1:0] pkt_ptr,
  output logic [1:0]       pio_mode,
  output logic             irq
);
  logic             mask_q, rst_q;
  logic [1:0]       pio_q;
  logic [7:0]       status_q, status_d;
  logic [CNT_W-1:0] cnt_q;
  logic [THR_W-1:0] tin_q, tout_q;
  logic [PTR_W-1:0] ptr_q;
  logic             go_q;
  logic             wr_ctrl, rd_stat, any_ev;

  assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
  assign rd_stat = reg_rd && (reg_addr == OFS_STAT);
  assign any_ev  = ev_buserr | ev_done | ev_unexp | ev_proto;

  always_comb begin
    status_d = status_q;
    if (rd_stat || rst_q) status_d = '0;
    if (ev_buserr) status_d[SB_BUSERR] = 1'b1;
    if (ev_done)   status_d[SB_DONE]   = 1'b1;
    if (ev_unexp)  status_d[SB_UNEXP]  = 1'b1;
    if (ev_proto)  status_d[SB_PROTO]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= 1'b0;
      rst_q    <= 1'b0;
      pio_q    <= '0;
      status_q <= '0;
      cnt_q    <= '0;
      tin_q    <= '0;
      tout_q   <= '0;
      ptr_q    <= '0;
      go_q     <= 1'b0;
    end else begin
      status_q <= status_d;
      go_q     <= wr_ctrl && reg_wdata[CB_GO];
      if (wr_ctrl) begin
        mask_q <= reg_wdata[CB_MASK];
        rst_q  <= reg_wdata[CB_RST];
        pio_q  <= reg_wdata[1:0];
      end
      if (reg_wr && reg_addr == OFS_CNT)  cnt_q  <= reg_wdata[CNT_W-1:0];
      if (reg_wr && reg_addr == OFS_PTR)  ptr_q  <= reg_wdata[PTR_W-1:0];
      if (reg_wr && reg_addr == OFS_TIN)  tin_q  <= reg_wdata[THR_W-1:0];
      if (reg_wr && reg_addr == OFS_TOUT) tout_q <= reg_wdata[THR_W-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_CTRL: reg_rdata = {23'd0, mask_q, 2'b00, rst_q, 3'b000, pio_q};
      OFS_STAT: reg_rdata = {24'd0, status_q};
      OFS_CNT:  reg_rdata = {{(32-CNT_W){1'b0}}, cnt_q};
      OFS_PTR:  reg_rdata = ptr_q;
      OFS_TIN:  reg_rdata = {{(32-THR_W){1'b0}}, tin_q};
      OFS_TOUT: reg_rdata = {{(32-THR_W){1'b0}}, tout_q};
      default:  reg_rdata = '0;
    endcase
  end

  assign go_pulse = go_q;
  assign soft_rst = rst_q;
  assign pkt_ptr  = ptr_q;
  assign pio_mode = pio_q;
  assign irq      = (status_q != 8'd0) && !mask_q;

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !any_ev) |=> (status_q == 8'd0)); // R9
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q && !any_ev) |=> (status_q == 8'd0)); // R11
endmodule

// File: rtl/pktchan_engine.sv
`timescale 1ns/1ps
module pktchan_engine
  import pktchan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             soft_rst,
  input  logic [PTR_W-1:0] pkt_ptr,
  output logic             mem_req,
  output logic             mem_we,
  output logic [WA_W-1:0]  mem_addr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             seq_start,
  output logic [PTR_W-1:0] seq_regs_ptr,
  output logic [9:0]       seq_pair_cnt,
  output logic [PTR_W-1:0] seq_prd_ptr,
  output logic             seq_has_data,
  input  logic             seq_done,
  input  logic             seq_dev_err,
  output logic             busy,
  output logic             ev_buserr,
  output logic             ev_done,
  output logic             ev_unexp,
  output logic             ev_proto
);
  eng_state_t       state;
  logic [PTR_W-1:0] base_q, prd_q;
  logic [7:0]       flags_q, len_q;
  logic             deverr_q;
  logic             hdr_valid;
  logic             accept_go;

  assign hdr_valid = mem_rdata[16 + HB_VALID];
  assign accept_go = (state == ST_IDLE) && go && !soft_rst;
  assign busy      = (state != ST_IDLE);

  assign ev_buserr = accept_go && misaligned(pkt_ptr);
  assign ev_proto  = !soft_rst && (state == ST_HDR0) && mem_ack && !hdr_valid;
  assign ev_done   = !soft_rst && (state == ST_RESP) && mem_ack && flags_q[HB_IEN];
  assign ev_unexp  = seq_done && (state != ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      base_q   <= '0;
      prd_q    <= '0;
      flags_q  <= '0;
      len_q    <= '0;
      deverr_q <= 1'b0;
    end else if (soft_rst) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (go && !misaligned(pkt_ptr)) begin
          base_q <= pkt_ptr;
          state  <= ST_HDR0;
        end
        ST_HDR0: if (mem_ack) begin
          flags_q <= mem_rdata[23:16];
          len_q   <= mem_rdata[31:24];
          state   <= hdr_valid ? ST_HDR2 : ST_IDLE;
        end
        ST_HDR2: if (mem_ack) begin
          prd_q <= mem_rdata;
          state <= ST_LAUNCH;
        end
        ST_LAUNCH: state <= ST_WAIT;
        ST_WAIT: if (seq_done) begin
          deverr_q <= seq_dev_err;
          state    <= ST_RESP;
        end
        ST_RESP: if (mem_ack) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = base_q[PTR_W-1:2];
    case (state)
      ST_HDR0: mem_req = 1'b1;
      ST_HDR2: begin
        mem_req  = 1'b1;
        mem_addr = base_q[PTR_W-1:2] + WA_W'(2);
      end
      ST_RESP: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
      end
      default: ;
    endcase
  end

  assign mem_be       = mem_we ? 4'b0001 : 4'b1111;
  assign mem_wdata    = {24'd0, resp_byte(deverr_q)};
  assign seq_start    = (state == ST_LAUNCH);
  assign seq_regs_ptr = pairs_base(base_q);
  assign seq_pair_cnt = pair_count(len_q);
  assign seq_prd_ptr  = prd_q;
  assign seq_has_data = flags_q[HB_DATA];

  AST_ONE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start); // R3
  AST_INVALID_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HDR0 && mem_ack && !hdr_valid && !soft_rst) |=> (!seq_start && !busy)); // R6
  AST_MISALIGN_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go && !soft_rst && misaligned(pkt_ptr)) |=> !busy); // R7
  AST_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go) |=> $stable(base_q)); // R10
  AST_SOFT_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!busy && !mem_req)); // R11
endmodule

// File: rtl/pktchan_ctrl.sv
`timescale 1ns/1ps
module pktchan_ctrl
  import pktchan_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int THR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [4:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [WA_W-1:0]  mem_addr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             seq_start,
  output logic [PTR_W-1:0] seq_regs_ptr,
  output logic [9:0]       seq_pair_cnt,
  output logic [PTR_W-1:0] seq_prd_ptr,
  output logic             seq_has_data,
  input  logic             seq_done,
  input  logic             seq_dev_err,
  output logic [1:0]       pio_mode,
  output logic             irq
);
  logic             go_pulse, soft_rst, busy;
  logic             ev_buserr, ev_done, ev_unexp, ev_proto;
  logic [PTR_W-1:0] pkt_ptr;

  pktchan_regs #(.CNT_W(CNT_W), .THR_W(THR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_buserr(ev_buserr), .ev_done(ev_done),
    .ev_unexp(ev_unexp), .ev_proto(ev_proto),
    .go_pulse(go_pulse), .soft_rst(soft_rst), .pkt_ptr(pkt_ptr),
    .pio_mode(pio_mode), .irq(irq)
  );

  pktchan_engine u_engine (
    .clk(clk), .rst_n(rst_n),
    .go(go_pulse), .soft_rst(soft_rst), .pkt_ptr(pkt_ptr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .seq_start(seq_start), .seq_regs_ptr(seq_regs_ptr),
    .seq_pair_cnt(seq_pair_cnt), .seq_prd_ptr(seq_prd_ptr),
    .seq_has_data(seq_has_data),
    .seq_done(seq_done), .seq_dev_err(seq_dev_err),
    .busy(busy),
    .ev_buserr(ev_buserr), .ev_done(ev_done),
    .ev_unexp(ev_unexp), .ev_proto(ev_proto)
  );

  AST_NO_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R7
endmodule

// File: tb/pktchan_ctrl_bench.sv
`timescale 1ns/1ps
module pktchan_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        seq_start, seq_has_data;
  logic [31:0] seq_regs_ptr, seq_prd_ptr;
  logic [9:0]  seq_pair_cnt;
  logic        seq_done = 1'b0, seq_dev_err = 1'b0;
  logic [1:0]  pio_mode;
  logic        irq;

  always #2.5 clk = ~clk;

  pktchan_ctrl u_pktchan_ctrl (.*);

  typedef struct packed {
    logic [31:0] rp; logic [9:0] pc; logic [31:0] prd; logic hd;
  } seq_exp_t;

  logic [31:0] mem [0:63];
  logic [29:0] exp_rd_q [$];
  logic [61:0] exp_wr_q [$];
  seq_exp_t    exp_seq_q [$];
  int total = 0, bad = 0;
  bit dev_err_cfg = 0, seq_hold = 0, done_req = 0;
  int seq_delay = 3;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // memory model and scoreboard for memory traffic
  initial forever begin
    @(negedge clk);
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        if (exp_wr_q.size() == 0) chk(0, "R4/R6/R11 unexpected write", {mem_addr, mem_wdata}, 0);
        else begin
          logic [61:0] e;
          e = exp_wr_q.pop_front();
          chk({mem_addr, mem_wdata} == e && mem_be == 4'b0001, "R4 response write",
              {mem_be, mem_addr, mem_wdata}, {4'b0001, e});
        end
        mem[mem_addr[5:0]][7:0] = mem_wdata[7:0];
      end else begin
        if (exp_rd_q.size() == 0) chk(0, "R3/R7/R10 unexpected read", mem_addr, 0);
        else begin
          logic [29:0] ea;
          ea = exp_rd_q.pop_front();
          chk(mem_addr == ea, "R3 fetch order", mem_addr, ea);
        end
        mem_rdata = mem[mem_addr[5:0]];
      end
    end
  end

  // sequencer model and scoreboard for launches
  initial forever begin
    int cnt;
    @(negedge clk);
    if (seq_done) seq_done = 1'b0;
    if (done_req) begin
      seq_done = 1'b1; seq_dev_err = 1'b0; done_req = 0;
    end else if (seq_start) begin
      if (exp_seq_q.size() == 0) chk(0, "R6/R10 unexpected launch", seq_regs_ptr, 0);
      else begin
        seq_exp_t e;
        e = exp_seq_q.pop_front();
        chk({seq_regs_ptr, seq_pair_cnt, seq_prd_ptr, seq_has_data} == e, "R3 launch fields",
            {seq_pair_cnt, seq_has_data, seq_regs_ptr[19:0]}, {e.pc, e.hd, e.rp[19:0]});
      end
      cnt = seq_hold ? 0 : seq_delay;
    end else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin seq_done = 1'b1; seq_dev_err = dev_err_cfg; end
    end
  end

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1; d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_packet(input logic [31:0] p, input logic [7:0] len, input logic hd,
                               input logic [31:0] prd, input logic [7:0] resp, input bit with_wr);
    exp_rd_q.push_back(p[31:2]);
    exp_rd_q.push_back(p[31:2] + 30'd2);
    exp_seq_q.push_back('{rp: p + 32'd16, pc: {len, 2'b00}, prd: prd, hd: hd});
    if (with_wr) exp_wr_q.push_back({p[31:2], 24'd0, resp});
  endtask

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[16] = 32'h030D0000; mem[18] = 32'h12345678;  // valid, data, ien, len 3
    mem[32] = 32'h00010000; mem[34] = 32'hCAFEF00D;  // valid only, len 0
    mem[48] = 32'h020C0000;                           // valid clear
    wait_cyc(3); rst_n = 1'b1; wait_cyc(2);

    reg_read(5'h00, d); chk(d == 0, "R1 ctrl reset", d, 0);
    reg_read(5'h02, d); chk(d == 0, "R1 status reset", d, 0);
    chk(irq == 0 && mem_req == 0, "R1 irq/mem_req reset", {irq, mem_req}, 0);

    reg_write(5'h04, 32'h0001);     reg_read(5'h04, d); chk(d == 32'h1, "R2 count", d, 1);
    reg_write(5'h14, 32'h0123);     reg_read(5'h14, d); chk(d == 32'h123, "R2 in thr", d, 32'h123);
    reg_write(5'h16, 32'hF456);     reg_read(5'h16, d); chk(d == 32'hF456, "R2 out thr", d, 32'hF456);
    reg_write(5'h0C, 32'h00000040); reg_read(5'h0C, d); chk(d == 32'h40, "R2 ptr", d, 32'h40);
    reg_write(5'h00, 32'h000001A3); wait_cyc(4);
    reg_read(5'h00, d); chk(d == 32'h123, "R2/R11 ctrl readback, go under reset ignored", d, 32'h123);
    chk(pio_mode == 2'd3, "R2 pio mode", pio_mode, 3);
    reg_write(5'h00, 32'h00000003);
    reg_read(5'h02, d); chk(d == 0, "R11 no packet under reset", d, 0);

    // R3 R4 R5 R9: full packet with interrupt enable
    expect_packet(32'h40, 8'd3, 1'b1, 32'h12345678, 8'h01, 1);
    reg_write(5'h00, 32'h00000083); wait_cyc(30);
    chk(irq == 1, "R9 irq after completion", irq, 1);
    reg_read(5'h02, d); chk(d == 32'h04, "R5 done status", d, 4);
    chk(irq == 0, "R9 irq after clear", irq, 0);
    reg_read(5'h02, d); chk(d == 0, "R9 read clears", d, 0);

    // R4 R5: no interrupt enable, device error
    dev_err_cfg = 1;
    reg_write(5'h0C, 32'h80);
    expect_packet(32'h80, 8'd0, 1'b0, 32'hCAFEF00D, 8'h09, 1);
    reg_write(5'h00, 32'h00000083); wait_cyc(30);
    reg_read(5'h02, d); chk(d == 0 && irq == 0, "R5 no ien leaves status", d, 0);
    dev_err_cfg = 0;

    // R9: masked completion
    reg_write(5'h0C, 32'h40);
    expect_packet(32'h40, 8'd3, 1'b1, 32'h12345678, 8'h01, 1);
    reg_write(5'h00, 32'h00000183); wait_cyc(30);
    chk(irq == 0, "R9 masked irq", irq, 0);
    reg_read(5'h02, d); chk(d == 32'h04, "R9 status kept under mask", d, 4);
    reg_write(5'h00, 32'h00000003);

    // R6: invalid header
    reg_write(5'h0C, 32'hC0);
    exp_rd_q.push_back(30'd48);
    reg_write(5'h00, 32'h00000083); wait_cyc(20);
    chk(irq == 1, "R6 irq on proto fault", irq, 1);
    reg_read(5'h02, d); chk(d == 32'h40, "R6 proto status", d, 32'h40);

    // R7: misaligned pointer
    reg_write(5'h0C, 32'h44);
    reg_write(5'h00, 32'h00000083); wait_cyc(10);
    reg_read(5'h02, d); chk(d == 32'h01, "R7 bus error status", d, 1);

    // R8: unexpected done while idle
    done_req = 1; wait_cyc(4);
    reg_read(5'h02, d); chk(d == 32'h10, "R8 unexpected done", d, 32'h10);

    // R10: go while busy
    seq_delay = 40;
    reg_write(5'h0C, 32'h40);
    expect_packet(32'h40, 8'd3, 1'b1, 32'h12345678, 8'h01, 1);
    reg_write(5'h00, 32'h00000083); wait_cyc(12);
    reg_write(5'h00, 32'h00000083); wait_cyc(60);
    reg_read(5'h02, d); chk(d == 32'h04, "R10 single completion", d, 4);
    seq_delay = 3;

    // R11: engine reset mid packet, then late done
    seq_hold = 1;
    expect_packet(32'h40, 8'd3, 1'b1, 32'h12345678, 8'h01, 0);
    reg_write(5'h00, 32'h00000083); wait_cyc(15);
    reg_write(5'h00, 32'h00000023); wait_cyc(3);
    chk(mem_req == 0, "R11 mem_req dropped", mem_req, 0);
    reg_read(5'h02, d); chk(d == 0, "R11 status clear under reset", d, 0);
    reg_write(5'h00, 32'h00000003);
    done_req = 1; wait_cyc(10);
    reg_read(5'h02, d); chk(d == 32'h10, "R11 late done is unexpected", d, 32'h10);
    seq_hold = 0;

    chk(exp_rd_q.size() == 0 && exp_wr_q.size() == 0 && exp_seq_q.size() == 0,
        "R3/R4 scoreboard drained", exp_rd_q.size() + exp_wr_q.size() + exp_seq_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule